// File: doc/BRIEF.md
# Transmit Page Chain Walker

This block sits on the transmit side of a switch port whose frames are kept in a shared paged packet memory. A receive path that has finished storing a frame hands over the pointer of the frame's first page. The walker keeps these pointers in a small start queue and serves them in arrival order. For each frame it follows the chain of pages. Every page begins with a header that gives the link to the following page and the number of data bytes the page holds. The walker reads those bytes and streams them, one per transfer, into a transmit data FIFO, with the first and last byte of the frame marked.

When the last byte of a frame has been taken by the FIFO, every page pointer the frame used is handed back to the shared free-page pool, one pointer per clock cycle, in chain order. The FIFO can push back at any time with a full flag. The byte on offer then stays put until it is taken.

The controller is a single state machine:

- IDLE waits for the queue and pops a pointer (IDLE→HDR0).
- HDR0, HDR1, HDR2 and HDR3 issue and collect the three header byte reads. HDR3→DRD adds the page to the frame's page list.
- DRD issues the first data read (DRD→DCAP).
- DCAP captures the returned byte (DCAP→DPUSH).
- DPUSH offers the byte. It waits in place while the FIFO is full. On acceptance it goes to DCAP while bytes remain in the page, to HDR0 for the next page, or to FREE at the end of the chain.
- FREE releases one pointer per cycle and returns to IDLE after the last one.

Top module: `tx_chain_walker`

## Requirements
- R1: Start pointers are served strictly in the order they were pushed. The queue holds 16 entries. A push and a pop in the same cycle both take effect.
- R2: While 16 pointers are queued, `desc_busy` is high and a push is refused. The refused pointer is never walked and never released.
- R3: Page header layout: byte offset 0 holds next-pointer bits 7:0, offset 1 holds next-pointer bits 10:8 in its bits 2:0, and offset 2 holds the byte count. Data bytes are read starting at offset 16, in increasing offset order.
- R4: A byte count of 0 is treated as 1, and a byte count above 240 is treated as 240.
- R5: A frame's pages are visited by following next pointers until a page whose next pointer is 11'h7FF. `tx_sof` marks the frame's first byte. `tx_eof` marks the last counted byte of the final page.
- R6: A chain is cut after its seventh page. That page ends the frame whatever its next pointer says.
- R7: A byte is transferred exactly when `tx_valid` is high and `tx_full` is low. While `tx_full` is high, the offered byte and its markers hold, and no byte is lost or repeated.
- R8: After the end-of-frame byte is accepted, the frame's page pointers appear on `free_ptr` in chain order, one per cycle on consecutive cycles, with no other pointer in between.
- R9: During and right after reset, `tx_valid`, `free_valid`, `mem_rd_en` and `desc_busy` are low.
- R10: Memory reads only touch header offsets 0 to 2 and data offsets 16 to 255 of a page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_push | input | 1 | Push a frame's first-page pointer |
| desc_ptr | input | 11 | First-page pointer being pushed |
| desc_busy | output | 1 | Start queue full; pushes are refused |
| mem_rd_en | output | 1 | Packet memory byte read request |
| mem_addr | output | 19 | Read address {page pointer, byte offset} |
| mem_rd_data | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| tx_valid | output | 1 | A frame byte is on offer |
| tx_data | output | 8 | Offered byte |
| tx_sof | output | 1 | Offered byte is the first of its frame |
| tx_eof | output | 1 | Offered byte is the last of its frame |
| tx_full | input | 1 | Transmit data FIFO cannot take a byte |
| free_valid | output | 1 | A page pointer is being returned this cycle |
| free_ptr | output | 11 | Returned page pointer |

## Verification
A descriptor push and the controller's dequeue of the queue head can land in the same cycle. The bench provokes this by pushing two pointers on consecutive edges from idle, so that the second push coincides with the pop of the first. The other collision is a push against a full queue while a frame is stalled. The bench holds `tx_full` high so that the first frame is stuck in DPUSH, fills the queue and pushes once more. Both cases are judged only at the ports: the frames' bytes must come out in push order, and the release list must contain every accepted pointer and not the refused one.

// File: rtl/txcw_pkg.sv
package txcw_pkg;

    // Controller states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR0,
        ST_HDR1,
        ST_HDR2,
        ST_HDR3,
        ST_DRD,
        ST_DCAP,
        ST_DPUSH,
        ST_FREE
    } walk_state_t;

    // Header byte positions within a page (decoded by the walker)
    localparam int HDR_NEXT_LO = 0;
    localparam int HDR_NEXT_HI = 1;
    localparam int HDR_COUNT   = 2;

    // First data byte offset and largest data payload of a page
    localparam int DATA_OFF = 16;
    localparam int DATA_MAX = 240;

    // Bring a raw header count into the legal range 1..DATA_MAX
    function automatic logic [7:0] clamp_count(input logic [7:0] raw);
        logic [7:0] res;
        if (raw == 8'd0)
            res = 8'd1;
        else if (raw > 8'(DATA_MAX))
            res = 8'(DATA_MAX);
        else
            res = raw;
        return res;
    endfunction

endpackage

// File: rtl/txcw_start_queue.sv
module txcw_start_queue #(
    parameter int W     = 11,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH):0]       level
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH) + 1;

    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] wr_idx;
    logic [AW-1:0] rd_idx;
    logic [LW-1:0] cnt;
    logic          do_push;
    logic          do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == LW'(DEPTH));
    assign level   = cnt;
    assign head    = slots[rd_idx];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push)
            slots[wr_idx] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            cnt    <= '0;
        end else begin
            if (do_push)
                wr_idx <= (wr_idx == AW'(DEPTH - 1)) ? '0 : wr_idx + 1'b1;
            if (do_pop)
                rd_idx <= (rd_idx == AW'(DEPTH - 1)) ? '0 : rd_idx + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/txcw_page_list.sv
module txcw_page_list #(
    parameter int W = 11,
    parameter int N = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     add,
    input  logic [W-1:0]             add_ptr,
    input  logic [$clog2(N+1)-1:0]   rd_idx,
    output logic [W-1:0]             rd_ptr,
    output logic [$clog2(N+1)-1:0]   count
);

    localparam int CW = $clog2(N + 1);

    logic [W-1:0]  slot [N];
    logic [CW-1:0] cnt;

    assign count  = cnt;
    assign rd_ptr = (rd_idx < CW'(N)) ? slot[rd_idx] : '0;

    // One register per list position, written when the list grows into it
    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[g] <= '0;
            else if (add && (cnt == CW'(g)))
                slot[g] <= add_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (add && (cnt < CW'(N)))
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/tx_chain_walker.sv
module tx_chain_walker
    import txcw_pkg::*;
#(
    parameter int PTR_W     = 11,
    parameter int OFF_W     = 8,
    parameter int QDEPTH    = 16,
    parameter int MAX_PAGES = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     desc_push,
    input  logic [PTR_W-1:0]         desc_ptr,
    output logic                     desc_busy,
    output logic                     mem_rd_en,
    output logic [PTR_W+OFF_W-1:0]   mem_addr,
    input  logic [7:0]               mem_rd_data,
    output logic                     tx_valid,
    output logic [7:0]               tx_data,
    output logic                     tx_sof,
    output logic                     tx_eof,
    input  logic                     tx_full,
    output logic                     free_valid,
    output logic [PTR_W-1:0]         free_ptr
);

    localparam int LW = $clog2(QDEPTH) + 1;
    localparam int CW = $clog2(MAX_PAGES + 1);
    localparam int HI_W = PTR_W - 8;
    localparam logic [PTR_W-1:0] END_PTR = '1;

    walk_state_t state, state_nx;

    // Queue side
    logic             q_pop;
    logic [PTR_W-1:0] q_head;
    logic             q_empty;
    logic             q_full;
    logic [LW-1:0]    q_level;

    // Page list side
    logic             list_clear;
    logic             list_add;
    logic [CW-1:0]    list_count;
    logic [PTR_W-1:0] list_rd;

    // Walker datapath
    logic [PTR_W-1:0] cur_ptr;
    logic [PTR_W-1:0] nxt_ptr;
    logic [OFF_W-1:0] offset;
    logic [7:0]       remain;
    logic [7:0]       data_q;
    logic             first_q;
    logic [CW-1:0]    rel_idx;

    logic             accept;
    logic             page_done;
    logic             chain_end;
    logic             rel_last;
    logic [7-HI_W:0]  hdr_hi_unused;

    assign hdr_hi_unused = mem_rd_data[7:HI_W];

    txcw_start_queue #(
        .W     (PTR_W),
        .DEPTH (QDEPTH)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (desc_push),
        .push_data (desc_ptr),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full),
        .level     (q_level)
    );

    txcw_page_list #(
        .W (PTR_W),
        .N (MAX_PAGES)
    ) u_pages (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (list_clear),
        .add     (list_add),
        .add_ptr (cur_ptr),
        .rd_idx  (rel_idx),
        .rd_ptr  (list_rd),
        .count   (list_count)
    );

    assign desc_busy = q_full;
    assign tx_data   = data_q;
    assign free_ptr  = list_rd;

    assign accept    = (state == ST_DPUSH) && !tx_full;
    assign page_done = (remain == 8'd1);
    assign chain_end = (nxt_ptr == END_PTR) || (list_count == CW'(MAX_PAGES));
    assign rel_last  = (rel_idx == list_count - 1'b1);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (!q_empty) state_nx = ST_HDR0;
            ST_HDR0:  state_nx = ST_HDR1;
            ST_HDR1:  state_nx = ST_HDR2;
            ST_HDR2:  state_nx = ST_HDR3;
            ST_HDR3:  state_nx = ST_DRD;
            ST_DRD:   state_nx = ST_DCAP;
            ST_DCAP:  state_nx = ST_DPUSH;
            ST_DPUSH: begin
                if (accept) begin
                    if (!page_done)
                        state_nx = ST_DCAP;
                    else if (chain_end)
                        state_nx = ST_FREE;
                    else
                        state_nx = ST_HDR0;
                end
            end
            ST_FREE:  if (rel_last) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs and strobes decoded from the state
    always_comb begin
        q_pop      = 1'b0;
        list_clear = 1'b0;
        list_add   = 1'b0;
        mem_rd_en  = 1'b0;
        mem_addr   = {cur_ptr, offset};
        tx_valid   = 1'b0;
        tx_sof     = 1'b0;
        tx_eof     = 1'b0;
        free_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                q_pop      = !q_empty;
                list_clear = 1'b1;
            end
            ST_HDR0: begin
                mem_rd_en = 1'b1;
                mem_addr  = {cur_ptr, OFF_W'(HDR_NEXT_LO)};
            end
            ST_HDR1: begin
                mem_rd_en = 1'b1;
                mem_addr  = {cur_ptr, OFF_W'(HDR_NEXT_HI)};
            end
            ST_HDR2: begin
                mem_rd_en = 1'b1;
                mem_addr  = {cur_ptr, OFF_W'(HDR_COUNT)};
            end
            ST_HDR3: begin
                list_add = 1'b1;
            end
            ST_DRD: begin
                mem_rd_en = 1'b1;
                mem_addr  = {cur_ptr, offset};
            end
            ST_DCAP: begin
            end
            ST_DPUSH: begin
                tx_valid  = 1'b1;
                tx_sof    = first_q;
                tx_eof    = page_done && chain_end;
                mem_rd_en = accept && !page_done;
                mem_addr  = {cur_ptr, offset + 1'b1};
            end
            ST_FREE: begin
                free_valid = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ptr <= '0;
            nxt_ptr <= '0;
            offset  <= '0;
            remain  <= '0;
            data_q  <= '0;
            first_q <= 1'b0;
            rel_idx <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    rel_idx <= '0;
                    if (!q_empty) begin
                        cur_ptr <= q_head;
                        first_q <= 1'b1;
                    end
                end
                ST_HDR1: nxt_ptr[7:0] <= mem_rd_data;
                ST_HDR2: nxt_ptr[PTR_W-1:8] <= mem_rd_data[HI_W-1:0];
                ST_HDR3: begin
                    remain <= clamp_count(mem_rd_data);
                    offset <= OFF_W'(DATA_OFF);
                end
                ST_DCAP: data_q <= mem_rd_data;
                ST_DPUSH: begin
                    if (accept) begin
                        first_q <= 1'b0;
                        offset  <= offset + 1'b1;
                        remain  <= remain - 1'b1;
                        if (page_done && !chain_end)
                            cur_ptr <= nxt_ptr;
                    end
                end
                ST_FREE: rel_idx <= rel_idx + 1'b1;
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/txcw_checker.sv
module txcw_checker #(
    parameter int OFF_W     = 8,
    parameter int QDEPTH    = 16,
    parameter int MAX_PAGES = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     desc_push,
    input  logic                     desc_busy,
    input  logic                     q_pop,
    input  logic [$clog2(QDEPTH):0]  q_level,
    input  logic                     mem_rd_en,
    input  logic [OFF_W-1:0]         rd_off,
    input  logic                     tx_valid,
    input  logic [7:0]               tx_data,
    input  logic                     tx_sof,
    input  logic                     tx_eof,
    input  logic                     tx_full,
    input  logic                     free_valid
);

    localparam int LW = $clog2(QDEPTH) + 1;
    localparam int RW = $clog2(MAX_PAGES + 1) + 1;

    logic [RW-1:0] free_run;

    always_ff @(posedge clk) begin
        if (!rst_n)
            free_run <= '0;
        else if (free_valid)
            free_run <= free_run + 1'b1;
        else
            free_run <= '0;
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_full) |=> (tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof)));

    // R5
    sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sof || tx_eof) |-> tx_valid);

    // R8
    release_follows_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_full && tx_eof) |=> free_valid);

    // R6
    release_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |-> (free_run < RW'(MAX_PAGES)));

    // R1
    queue_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_push && !desc_busy && !q_pop) |=> (q_level == LW'($past(q_level) + 1'b1)));

    // R2
    queue_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_push && desc_busy && !q_pop) |=> (q_level == $past(q_level)));

    // R10
    read_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> ((rd_off < OFF_W'(3)) || (rd_off >= OFF_W'(16))));

endmodule

bind tx_chain_walker txcw_checker #(
    .OFF_W     (OFF_W),
    .QDEPTH    (QDEPTH),
    .MAX_PAGES (MAX_PAGES)
) u_txcw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_push  (desc_push),
    .desc_busy  (desc_busy),
    .q_pop      (q_pop),
    .q_level    (q_level),
    .mem_rd_en  (mem_rd_en),
    .rd_off     (mem_addr[OFF_W-1:0]),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_sof     (tx_sof),
    .tx_eof     (tx_eof),
    .tx_full    (tx_full),
    .free_valid (free_valid)
);

// File: tb/test_tx_chain_walker.sv
module test_tx_chain_walker;

    localparam int PTR_W  = 11;
    localparam int NPAGES = 64;
    localparam logic [10:0] END_MARK = 11'h7FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_push = 1'b0;
    logic [10:0] desc_ptr = '0;
    logic        desc_busy;
    logic        mem_rd_en;
    logic [18:0] mem_addr;
    logic [7:0]  mem_rd_data = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_sof;
    logic        tx_eof;
    logic        tx_full = 1'b0;
    logic        free_valid;
    logic [10:0] free_ptr;

    tx_chain_walker i_tx_chain_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .desc_push   (desc_push),
        .desc_ptr    (desc_ptr),
        .desc_busy   (desc_busy),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .mem_rd_data (mem_rd_data),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .tx_sof      (tx_sof),
        .tx_eof      (tx_eof),
        .tx_full     (tx_full),
        .free_valid  (free_valid),
        .free_ptr    (free_ptr)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int bad_rd = 0;
    int stall_mode = 0;

    logic [7:0] pmem [NPAGES*256];

    int   rx_data [$];
    bit   rx_sof  [$];
    bit   rx_eof  [$];
    int   fr_ptr  [$];
    int   fr_cyc  [$];
    int   ex_data [$];
    bit   ex_sof  [$];
    bit   ex_eof  [$];
    int   ex_free [$];
    int   ex_frames = 0;

    // Cycle count and watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Packet memory: one cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) begin
            if (mem_addr[7:0] >= 8'd3 && mem_addr[7:0] < 8'd16)
                bad_rd = bad_rd + 1;
            if (int'(mem_addr) < NPAGES*256)
                mem_rd_data <= pmem[int'(mem_addr)];
            else
                mem_rd_data <= 8'hEE;
        end
    end

    // FIFO model and release collector, away from the active edge
    always @(negedge clk) begin
        case (stall_mode)
            1:       tx_full = ((cyc % 3) == 0);
            2:       tx_full = 1'b1;
            default: tx_full = 1'b0;
        endcase
        if (rst_n && tx_valid && !tx_full) begin
            rx_data.push_back(int'(tx_data));
            rx_sof.push_back(tx_sof);
            rx_eof.push_back(tx_eof);
        end
        if (rst_n && free_valid) begin
            fr_ptr.push_back(int'(free_ptr));
            fr_cyc.push_back(cyc);
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic build_page(input int p, input logic [10:0] nxt, input logic [7:0] cnt);
        pmem[p*256 + 0] = nxt[7:0];
        pmem[p*256 + 1] = {5'b10100, nxt[10:8]};
        pmem[p*256 + 2] = cnt;
        for (int i = 3; i < 256; i++)
            pmem[p*256 + i] = 8'((p * 37 + i * 11 + 3) & 255);
    endtask

    function automatic int clamp_exp(input int c);
        if (c == 0) return 1;
        if (c > 240) return 240;
        return c;
    endfunction

    // Expected stream for one frame, walked from the requirements
    task automatic add_expected(input int start);
        int p = start;
        int pages = 0;
        int first = ex_data.size();
        while (1) begin
            int cnt = clamp_exp(int'(pmem[p*256 + 2]));
            int nxt = int'({pmem[p*256 + 1][2:0], pmem[p*256 + 0]});
            for (int i = 0; i < cnt; i++) begin
                ex_data.push_back(int'(pmem[p*256 + 16 + i]));
                ex_sof.push_back(ex_data.size() - 1 == first);
                ex_eof.push_back(1'b0);
            end
            ex_free.push_back(p);
            pages++;
            if (nxt == int'(END_MARK) || pages == 7) break;
            p = nxt;
        end
        ex_eof[ex_eof.size() - 1] = 1'b1;
        ex_frames++;
    endtask

    task automatic clear_all();
        rx_data.delete(); rx_sof.delete(); rx_eof.delete();
        fr_ptr.delete(); fr_cyc.delete();
        ex_data.delete(); ex_sof.delete(); ex_eof.delete(); ex_free.delete();
        ex_frames = 0;
    endtask

    task automatic push_desc(input int p);
        desc_push = 1'b1;
        desc_ptr  = 11'(p);
        @(negedge clk);
        desc_push = 1'b0;
    endtask

    task automatic wait_and_compare(input string req);
        int n = 0;
        int mism = -1;
        int fmis = -1;
        int gaps = 0;
        while ((rx_data.size() < ex_data.size() || fr_ptr.size() < ex_free.size()) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (12) @(negedge clk);
        chk(n < 20000, req, "completion wait", n, 20000);
        chk(rx_data.size() == ex_data.size(), req, "byte count", rx_data.size(), ex_data.size());
        for (int i = 0; i < rx_data.size() && i < ex_data.size(); i++)
            if (mism < 0 && (rx_data[i] != ex_data[i] || rx_sof[i] != ex_sof[i] || rx_eof[i] != ex_eof[i]))
                mism = i;
        chk(mism < 0, req, "first stream mismatch index", mism, -1);
        chk(fr_ptr.size() == ex_free.size(), req, "released pointer count", fr_ptr.size(), ex_free.size());
        for (int i = 0; i < fr_ptr.size() && i < ex_free.size(); i++)
            if (fmis < 0 && fr_ptr[i] != ex_free[i])
                fmis = i;
        chk(fmis < 0, req, "first release mismatch index", fmis, -1);
        for (int i = 1; i < fr_cyc.size(); i++)
            if (fr_cyc[i] != fr_cyc[i-1] + 1)
                gaps++;
        chk(gaps == ex_frames - 1, req, "release bursts minus one", gaps, ex_frames - 1);
    endtask

    // R9: reset state
    task automatic t_reset();
        chk(!tx_valid && !free_valid && !mem_rd_en && !desc_busy, "R9", "outputs in reset",
            {tx_valid, free_valid, mem_rd_en, desc_busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_valid && !free_valid && !mem_rd_en && !desc_busy, "R9", "outputs after reset",
            {tx_valid, free_valid, mem_rd_en, desc_busy}, 0);
    endtask

    // R3, R5, R8: one page, five bytes
    task automatic t_single();
        clear_all();
        stall_mode = 0;
        build_page(1, END_MARK, 8'd5);
        add_expected(1);
        push_desc(1);
        wait_and_compare("R3/R5/R8 single page");
    endtask

    // R5, R7, R8: three-page chain under FIFO back-pressure
    task automatic t_chain_stall();
        clear_all();
        build_page(2, 11'd3, 8'd240);
        build_page(3, 11'd4, 8'd1);
        build_page(4, END_MARK, 8'd17);
        add_expected(2);
        stall_mode = 1;
        push_desc(2);
        wait_and_compare("R5/R7/R8 stalled chain");
        stall_mode = 0;
    endtask

    // R4, R1: clamped counts on two queued frames
    task automatic t_clamp();
        clear_all();
        build_page(5, END_MARK, 8'd0);
        build_page(6, END_MARK, 8'd250);
        add_expected(5);
        add_expected(6);
        push_desc(5);
        push_desc(6);
        wait_and_compare("R4/R1 count clamp");
    endtask

    // R6: nine-page chain cut after seven
    task automatic t_long();
        clear_all();
        for (int p = 40; p < 48; p++)
            build_page(p, 11'(p + 1), 8'd3);
        build_page(48, END_MARK, 8'd3);
        add_expected(40);
        push_desc(40);
        wait_and_compare("R6 chain limit");
        chk(rx_data.size() == 21, "R6", "bytes of seven pages", rx_data.size(), 21);
    endtask

    // R1: second push in the cycle the first is dequeued
    task automatic t_back2back();
        clear_all();
        build_page(7, END_MARK, 8'd4);
        build_page(8, END_MARK, 8'd6);
        add_expected(7);
        add_expected(8);
        push_desc(7);
        push_desc(8);
        wait_and_compare("R1 push during pop");
    endtask

    // R2: full queue refuses the extra push
    task automatic t_busy();
        clear_all();
        for (int p = 20; p <= 37; p++)
            build_page(p, END_MARK, 8'd2);
        stall_mode = 2;
        push_desc(20);
        repeat (12) @(negedge clk);
        chk(!desc_busy, "R2", "busy with one frame stalled", desc_busy, 0);
        for (int p = 21; p <= 36; p++)
            push_desc(p);
        chk(desc_busy, "R2", "busy with sixteen queued", desc_busy, 1);
        push_desc(37);
        repeat (3) @(negedge clk);
        chk(rx_data.size() == 0, "R7", "no byte taken while full", rx_data.size(), 0);
        for (int p = 20; p <= 36; p++)
            add_expected(p);
        stall_mode = 0;
        wait_and_compare("R2/R1 refused push");
        chk(!desc_busy, "R2", "busy after drain", desc_busy, 0);
    endtask

    initial begin
        for (int i = 0; i < NPAGES*256; i++)
            pmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        t_single();
        t_chain_stall();
        t_clamp();
        t_long();
        t_back2back();
        t_busy();
        chk(bad_rd == 0, "R10", "reads inside header gap", bad_rd, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule